// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the memory-mapped front end of a multi-channel event timer. A 32-bit register bus reaches a free-running 64-bit tick counter, a global control word, a read-only identification word and a tick-period word. It also reaches a row of per-channel register windows, which hold each channel's control word, 64-bit comparator and 64-bit route word. The comparator logic and the interrupt router sit outside the block. They see the live counter, the global enable and legacy-route bits, one write strobe per channel, and one-cycle arm and disarm pulses per channel.

Setting the global enable bit starts the counter from the value it holds. The same write arms every channel whose comparator has been programmed, meaning it is not all-ones. Clearing the bit freezes the counter and disarms every channel. Software can load the counter as two independent 32-bit halves. The channel count is a parameter clamped to the range 3 to 32. Windows beyond the implemented count, or beyond the end of the map, behave as empty.

Top module: `evt_timer_regs`

## Requirements
- R1: The word at 0x000 is read-only and reads revision 0x01 in bits 7:0, the channel count minus one in bits 12:8, a 64-bit counter flag in bit 13 and a legacy-route flag in bit 15, with all other bits zero (0x0000A201 for three channels). The word at 0x004 reads the tick period in femtoseconds, which is 20,000,000 by default. Writes to either word change nothing.
- R2: The control word at 0x010 stores only bit 0 (enable) and bit 1 (legacy route), which appear on en_o and legacy_o, and its other bits read zero. The word at 0x014 reads zero and ignores writes.
- R3: The counter holds its value while enable is 0. While enable is 1 it increments by one every clock, carrying from the low half into the high half.
- R4: The counter low half at 0x0F0 and high half at 0x0F4 are written separately, and a write leaves the other half unchanged. A write while enabled loads the value at that edge, and counting resumes from it on the next edge.
- R5: A write that takes enable from 0 to 1 pulses arm_o for one cycle, on exactly the channels whose 64-bit comparator is not all-ones. A write that leaves enable at 1 pulses nothing.
- R6: A write that takes enable from 1 to 0 pulses disarm_o on every channel for one cycle and freezes the counter.
- R7: Channel n has its window at 0x100 + 0x20*n, with the control word at +0x00, the comparator at +0x08 and the route word at +0x10. The low 32 bits of each sit at +0, the high 32 bits at +4, and each of these words reads back what was written. The word at +0x04 reads the route capability mask (0x00000F00 by default) and ignores writes.
- R8: A window whose index is not below the channel count reads zero, ignores writes and raises no channel strobe.
- R9: Read data appears on rdata_o one cycle after re_i and holds until the next read. Unmapped addresses read zero.
- R10: After reset the counter, control word, arm and disarm outputs and read data are zero, every channel comparator is all-ones, and channel control and route words are zero.
- R11: The word at 0x020 reads sts_i in its low bits and ignores writes.
- R12: During a write cycle to channel n, ch_we_o has only bit n set, ch_off_o carries the offset within the window (address bits 4:0), and ch_wdata_o carries the write data. Writes outside the channel windows leave ch_we_o at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| sts_i | input | NCH | Per-channel interrupt status, read at 0x020 |
| cnt_o | output | 64 | Live main counter |
| en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy route select |
| ch_we_o | output | NCH | Per-channel write strobe |
| ch_off_o | output | 5 | Offset within the channel window |
| ch_wdata_o | output | 32 | Write data fanned out to the channels |
| arm_o | output | NCH | One-cycle arm pulse per channel |
| disarm_o | output | NCH | One-cycle disarm pulse per channel |

## Verification
The properties assume one bus access per cycle with word-aligned addresses, and they assume that read and write strobes are never raised together. They also treat a counter load as overriding the increment in the cycle it occurs. The stimulus drives every access for exactly one cycle from the falling edge, always on 4-byte aligned addresses and never with both strobes set. It holds sts_i steady around each status read, so that the value captured by the registered read is known.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int MIN_CH = 3;
  localparam int MAX_CH = 32;
  localparam int AW     = 10;

  localparam logic [AW-1:0] A_ID   = 10'h000;
  localparam logic [AW-1:0] A_PER  = 10'h004;
  localparam logic [AW-1:0] A_CFG  = 10'h010;
  localparam logic [AW-1:0] A_STS  = 10'h020;
  localparam logic [AW-1:0] A_CNTL = 10'h0F0;
  localparam logic [AW-1:0] A_CNTH = 10'h0F4;

  localparam logic [4:0] O_CFGL = 5'h00;
  localparam logic [4:0] O_CFGH = 5'h04;
  localparam logic [4:0] O_CMPL = 5'h08;
  localparam logic [4:0] O_CMPH = 5'h0C;
  localparam logic [4:0] O_RTL  = 5'h10;
  localparam logic [4:0] O_RTH  = 5'h14;

  typedef enum logic [2:0] {
    T_NONE, T_ID, T_PER, T_CFG, T_STS, T_CNTL, T_CNTH, T_CH
  } tgt_e;

  function automatic int clamp_ch(input int n);
    return (n < MIN_CH) ? MIN_CH : ((n > MAX_CH) ? MAX_CH : n);
  endfunction
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o,
  output logic [4:0]    idx_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = addr_i[9:5] - 5'd8;
    hit_o = 1'b0;
    tgt_o = T_NONE;
    if (addr_i[9:8] != 2'b00) begin
      tgt_o = T_CH;
      hit_o = (int'(idx_o) < NCH);
    end else begin
      unique case (addr_i)
        A_ID:    tgt_o = T_ID;
        A_PER:   tgt_o = T_PER;
        A_CFG:   tgt_o = T_CFG;
        A_STS:   tgt_o = T_STS;
        A_CNTL:  tgt_o = T_CNTL;
        A_CNTH:  tgt_o = T_CNTH;
        default: tgt_o = T_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] cnt_o
);
  localparam int HW = CW / 2;

  // software load wins over the increment in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (we_lo_i) cnt_o <= {cnt_o[CW-1:HW], wdata_i[HW-1:0]};
    else if (we_hi_i) cnt_o <= {wdata_i[HW-1:0], cnt_o[HW-1:0]};
    else if (en_i)    cnt_o <= cnt_o + {{(CW-1){1'b0}}, 1'b1};
  end

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !we_lo_i && !we_hi_i) |=> $stable(cnt_o));
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_lo_i && !we_hi_i) |=> (cnt_o == $past(cnt_o) + 1));
  a_r4_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i |=> (cnt_o[CW-1:HW] == $past(cnt_o[CW-1:HW])));
  a_r4_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i) |=> (cnt_o[HW-1:0] == $past(cnt_o[HW-1:0])));
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [4:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rword_o,
  output logic        unset_o
);
  logic [31:0] cfg_q;
  logic [63:0] cmp_q;
  logic [63:0] rt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= '1;
      rt_q  <= '0;
    end else if (we_i) begin
      case (off_i)
        O_CFGL:  cfg_q        <= wdata_i;
        O_CMPL:  cmp_q[31:0]  <= wdata_i;
        O_CMPH:  cmp_q[63:32] <= wdata_i;
        O_RTL:   rt_q[31:0]   <= wdata_i;
        O_RTH:   rt_q[63:32]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off_i)
      O_CFGL:  rword_o = cfg_q;
      O_CFGH:  rword_o = ROUTE_CAP;
      O_CMPL:  rword_o = cmp_q[31:0];
      O_CMPH:  rword_o = cmp_q[63:32];
      O_RTL:   rword_o = rt_q[31:0];
      O_RTH:   rword_o = rt_q[63:32];
      default: rword_o = '0;
    endcase
  end

  // an all-ones comparator marks the channel as never programmed
  assign unset_o = &cmp_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd20_000_000,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00,
  localparam int         NCH       = clamp_ch(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            we_i,
  input  logic            re_i,
  output logic [31:0]     rdata_o,
  input  logic [NCH-1:0]  sts_i,
  output logic [63:0]     cnt_o,
  output logic            en_o,
  output logic            legacy_o,
  output logic [NCH-1:0]  ch_we_o,
  output logic [4:0]      ch_off_o,
  output logic [31:0]     ch_wdata_o,
  output logic [NCH-1:0]  arm_o,
  output logic [NCH-1:0]  disarm_o
);
  localparam logic [4:0]  NCH_M1  = 5'(NCH - 1);
  localparam logic [31:0] ID_WORD = {16'h0, 1'b1, 1'b0, 1'b1, NCH_M1, 8'h01};

  tgt_e        tgt;
  logic [4:0]  idx;
  logic        hit;
  logic        en_q, leg_q;
  logic        cfg_we, rise, fall;
  logic [NCH-1:0] ch_sel, ch_unset, arm_q, disarm_q;
  logic [31:0] ch_rd [NCH];
  logic [31:0] ch_rword, rd_mux, rdata_q;

  evt_addr_decode #(.NCH(NCH)) u_dec (
    .addr_i (addr_i),
    .tgt_o  (tgt),
    .idx_o  (idx),
    .hit_o  (hit)
  );

  evt_main_counter #(.CW(64)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .we_lo_i (we_i && tgt == T_CNTL),
    .we_hi_i (we_i && tgt == T_CNTH),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_o)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_sel[n]  = hit && (idx == 5'(n));
    assign ch_we_o[n] = we_i && ch_sel[n];
    evt_chan_regs #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ch_we_o[n]),
      .off_i   (addr_i[4:0]),
      .wdata_i (wdata_i),
      .rword_o (ch_rd[n]),
      .unset_o (ch_unset[n])
    );
  end

  assign ch_off_o   = addr_i[4:0];
  assign ch_wdata_o = wdata_i;

  // global control: only enable and legacy bits exist
  assign cfg_we = we_i && (tgt == T_CFG);
  assign rise   = cfg_we &&  wdata_i[0] && !en_q;
  assign fall   = cfg_we && !wdata_i[0] &&  en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      leg_q    <= 1'b0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= wdata_i[0];
        leg_q <= wdata_i[1];
      end
      arm_q    <= rise ? ~ch_unset : '0;
      disarm_q <= fall ? '1 : '0;
    end
  end

  assign en_o     = en_q;
  assign legacy_o = leg_q;
  assign arm_o    = arm_q;
  assign disarm_o = disarm_q;

  always_comb begin
    ch_rword = '0;
    for (int n = 0; n < NCH; n++)
      if (ch_sel[n]) ch_rword = ch_rword | ch_rd[n];
  end

  always_comb begin
    case (tgt)
      T_ID:    rd_mux = ID_WORD;
      T_PER:   rd_mux = PERIOD_FS;
      T_CFG:   rd_mux = {30'd0, leg_q, en_q};
      T_STS:   rd_mux = 32'(sts_i);
      T_CNTL:  rd_mux = cnt_o[31:0];
      T_CNTH:  rd_mux = cnt_o[63:32];
      T_CH:    rd_mux = ch_rword;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  a_r5_arm_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arm_q) |-> (en_q && !$past(en_q)));
  a_r6_disarm_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> (disarm_q == '1));
  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable({leg_q, en_q}));
  a_r12_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we_o));
  a_r8_oob_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |-> (ch_we_o == '0));
  a_r9_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  sts = '0;
  logic [63:0] cnt;
  logic        en, leg;
  logic [2:0]  ch_we, arm, disarm;
  logic [4:0]  ch_off;
  logic [31:0] ch_wdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  evt_timer_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .sts_i(sts), .cnt_o(cnt),
    .en_o(en), .legacy_o(leg), .ch_we_o(ch_we), .ch_off_o(ch_off),
    .ch_wdata_o(ch_wdata), .arm_o(arm), .disarm_o(disarm)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // {wr, addr, wdata, expected, req}
  localparam int NV = 26;
  localparam logic [82:0] VEC [NV] = '{
    {1'b0, 10'h000, 32'h0,         32'h0000A201, 8'd1},  // R1 id
    {1'b1, 10'h000, 32'hFFFFFFFF,  32'h0,        8'd1},
    {1'b0, 10'h000, 32'h0,         32'h0000A201, 8'd1},  // R1 write ignored
    {1'b0, 10'h004, 32'h0,         32'h01312D00, 8'd1},  // R1 period
    {1'b1, 10'h010, 32'hFFFFFFFC,  32'h0,        8'd2},
    {1'b0, 10'h010, 32'h0,         32'h0,        8'd2},  // R2 other bits dropped
    {1'b1, 10'h014, 32'hFFFFFFFF,  32'h0,        8'd2},
    {1'b0, 10'h014, 32'h0,         32'h0,        8'd2},  // R2 upper word
    {1'b1, 10'h010, 32'h00000002,  32'h0,        8'd2},
    {1'b0, 10'h010, 32'h0,         32'h00000002, 8'd2},  // R2 legacy bit
    {1'b1, 10'h010, 32'h00000000,  32'h0,        8'd2},
    {1'b1, 10'h108, 32'hDEADBEEF,  32'h0,        8'd7},
    {1'b0, 10'h108, 32'h0,         32'hDEADBEEF, 8'd7},  // R7 ch0 cmp lo
    {1'b0, 10'h10C, 32'h0,         32'hFFFFFFFF, 8'd10}, // R10 cmp hi default
    {1'b1, 10'h134, 32'h00001234,  32'h0,        8'd7},
    {1'b0, 10'h134, 32'h0,         32'h00001234, 8'd7},  // R7 ch1 route hi
    {1'b0, 10'h130, 32'h0,         32'h0,        8'd7},  // R7 route lo untouched
    {1'b1, 10'h144, 32'hFFFFFFFF,  32'h0,        8'd7},
    {1'b0, 10'h144, 32'h0,         32'h00000F00, 8'd7},  // R7 cap word read-only
    {1'b1, 10'h140, 32'h000000A5,  32'h0,        8'd7},
    {1'b0, 10'h140, 32'h0,         32'h000000A5, 8'd7},  // R7 ch2 cfg
    {1'b1, 10'h168, 32'h11111111,  32'h0,        8'd8},
    {1'b0, 10'h168, 32'h0,         32'h0,        8'd8},  // R8 beyond count
    {1'b0, 10'h118, 32'h0,         32'h0,        8'd9},  // R9 unmapped offset
    {1'b0, 10'h030, 32'h0,         32'h0,        8'd9},  // R9 unmapped global
    {1'b0, 10'h0F0, 32'h0,         32'h0,        8'd10}  // R10 counter
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, a0, b0;
    string tag;
    @(negedge clk);
    // R10 reset state at the ports
    chk("R10 rdata", 64'(rdata), 64'h0);
    chk("R10 cnt", cnt, 64'h0);
    chk("R10 en/arm/disarm", 64'({en, leg, arm, disarm}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][82]) wr(VEC[i][81:72], VEC[i][71:40]);
      else begin
        rd(VEC[i][81:72], d);
        tag = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
        chk(tag, 64'(d), 64'(VEC[i][39:8]));
      end
    end

    // R11 status word
    sts = 3'b101;
    rd(10'h020, d); chk("R11 status", 64'(d), 64'h5);
    wr(10'h020, 32'hFFFFFFFF);
    rd(10'h020, d); chk("R11 write ignored", 64'(d), 64'h5);

    // R9 read data holds without a read strobe
    repeat (3) @(negedge clk);
    chk("R9 hold", 64'(rdata), 64'h5);

    // R12 strobe fan-out
    addr = 10'h140; wdata = 32'h0BAD_F00D; we = 1'b1; #1;
    chk("R12 ch2 strobe", 64'({ch_we, ch_off}), {56'h0, 3'b100, 5'h00});
    chk("R12 wdata fanout", 64'(ch_wdata), 64'h0BADF00D);
    @(negedge clk); we = 1'b0;
    addr = 10'h128; wdata = 32'h1; we = 1'b1; #1;
    chk("R12 ch1 strobe", 64'({ch_we, ch_off}), {56'h0, 3'b010, 5'h08});
    @(negedge clk); we = 1'b0;
    addr = 10'h168; we = 1'b1; #1;
    chk("R8 no strobe", 64'(ch_we), 64'h0);
    @(negedge clk); we = 1'b0;
    addr = 10'h010; wdata = 32'h0; we = 1'b1; #1;
    chk("R12 global no strobe", 64'(ch_we), 64'h0);
    @(negedge clk); we = 1'b0;

    // R10 mid-run reset restores defaults
    do_reset();
    rd(10'h108, d); chk("R10 cmp lo default", 64'(d), 64'hFFFFFFFF);
    rd(10'h140, d); chk("R10 cfg default", 64'(d), 64'h0);
    rd(10'h134, d); chk("R10 route default", 64'(d), 64'h0);

    // R4 independent halves
    wr(10'h0F0, 32'hFFFFFFFE);
    wr(10'h0F4, 32'h00000005);
    rd(10'h0F0, d); chk("R4 lo", 64'(d), 64'hFFFFFFFE);
    rd(10'h0F4, d); chk("R4 hi", 64'(d), 64'h5);
    // R3 count with carry: 6 increments before disable lands
    wr(10'h010, 32'h1);
    repeat (5) @(negedge clk);
    wr(10'h010, 32'h0);
    rd(10'h0F4, d); chk("R3 carry hi", 64'(d), 64'h6);
    rd(10'h0F0, d); chk("R3 lo", 64'(d), 64'h4);
    // R6 frozen while disabled
    repeat (10) @(negedge clk);
    rd(10'h0F0, d); chk("R6 frozen", 64'(d), 64'h4);
    chk("R3 cnt_o frozen", cnt, 64'h0000_0006_0000_0004);
    // R3 live reads differ by elapsed clocks
    wr(10'h010, 32'h1);
    rd(10'h0F0, a0);
    repeat (7) @(negedge clk);
    rd(10'h0F0, b0);
    chk("R3 live delta", 64'(b0 - a0), 64'd8);
    // R4 write while enabled
    wr(10'h0F0, 32'h00000100);
    wr(10'h010, 32'h0);
    rd(10'h0F0, d); chk("R4 load while enabled", 64'(d), 64'h101);

    // R5/R6 arm and disarm
    do_reset();
    wr(10'h128, 32'h00000050);
    wr(10'h010, 32'h1);
    chk("R5 arm programmed only", 64'({arm, disarm}), {58'h0, 3'b010, 3'b000});
    chk("R2 en_o", 64'(en), 64'h1);
    @(negedge clk);
    chk("R5 arm one cycle", 64'(arm), 64'h0);
    wr(10'h010, 32'h3);
    chk("R5 no rearm", 64'(arm), 64'h0);
    chk("R2 legacy_o", 64'(leg), 64'h1);
    wr(10'h010, 32'h0);
    chk("R6 disarm all", 64'({arm, disarm}), {58'h0, 3'b000, 3'b111});
    chk("R6 en_o low", 64'(en), 64'h0);
    @(negedge clk);
    chk("R6 disarm one cycle", 64'(disarm), 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule